// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed-BCD Arithmetic

This block is the purely combinational arithmetic and logic unit of a small accumulator-style processor. Each cycle the surrounding datapath presents an operation code, the accumulator value, a second operand, the current carry and the decimal-mode setting. In the same cycle the block returns an eight-bit result and candidate values for the negative, zero, carry and overflow flags. Register storage, operand fetch and instruction decode stay outside the block.

Each flag comes with its own update-enable. The caller writes a flag into its status register only when that enable is high, so operations that leave a flag alone need no extra decode in the caller. A flag output whose enable is low carries no defined value.

In decimal mode, add and subtract treat both operands as two packed BCD digits. Each nibble is corrected separately. The flags in that mode are taken from intermediate or binary values, not from the corrected result, so that programs which depend on those exact flag values keep working.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 with decimal_i low gives result = (a_i + b_i + carry_i) mod 256. C is bit 8 of the 9-bit sum. V is set when a_i and b_i have the same sign bit and the result's sign bit differs from it. N is result bit 7 and Z means result is zero. All four enables are high.
- R2: Op code 0 with decimal_i high adds the low nibbles and carry_i, then adds 6 when that low sum is 10 or more. It then adds the high nibbles (each weighted 16) to this corrected low sum, adds 0x60 when the total is 0xA0 or more, and takes C from bit 8 of the corrected 9-bit total. The result is the low 8 bits.
- R3: In decimal add, Z reflects the plain binary sum a_i + b_i + carry_i. N is bit 7 of the high total before its 0x60 correction, and V applies the R1 sign rule to that same uncorrected total.
- R4: Op code 1 with decimal_i low gives result = (a_i - b_i - (1 - carry_i)) mod 256. C is set when no borrow occurs. V is set when the operands differ in sign and the result's sign differs from a_i. N and Z come from the result, and all four enables are high.
- R5: Op code 1 with decimal_i high subtracts the low nibbles with borrow and subtracts 6 more when that goes negative. It then subtracts the high parts, plus 16 more on a low borrow, and subtracts 0x60 when that goes negative. N, Z, C and V are the binary values of R4.
- R6: Op code 2 (compare) computes a_i - b_i with no borrow-in, in binary, whatever carry_i and decimal_i are. N, Z and C update as in R4. V is not enabled, and the result is a_i.
- R7: Op codes 3, 4 and 5 give a_i AND, OR and XOR b_i. Only N and Z are enabled.
- R8: Op code 6 (bit test) sets N to b_i bit 7, V to b_i bit 6, and Z when a_i AND b_i is zero. C is not enabled, and the result is a_i.
- R9: Op codes 7 (shift left) and 8 (logical shift right) move a_i one place and fill the vacated bit with 0. C receives the bit shifted out, and N, Z and C are enabled.
- R10: Op codes 9 (rotate left) and 10 (rotate right) move a_i one place through carry. carry_i fills the vacated bit and C receives the bit shifted out. N, Z and C are enabled.
- R11: Op codes 11 and 12 give a_i + 1 and a_i - 1, wrapping modulo 256. Only N and Z are enabled.
- R12: Op codes 13 to 15 are reserved. They give result = a_i with all four enables low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Current carry flag |
| decimal_i | input | 1 | Decimal-mode flag for add and subtract |
| result_o | output | 8 | Operation result |
| flag_n_o | output | 1 | Negative flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_c_o | output | 1 | Carry flag value |
| flag_v_o | output | 1 | Overflow flag value |
| upd_n_o | output | 1 | Write enable for N |
| upd_z_o | output | 1 | Write enable for Z |
| upd_c_o | output | 1 | Write enable for C |
| upd_v_o | output | 1 | Write enable for V |

## Verification
No register lies between any input and any output, so every result, flag and enable is due in the same cycle as its stimulus. The driver applies each vector just after a rising edge and queues its expected item at that moment. The monitor pops that item at the following falling edge, when the combinational outputs have settled and before the next vector arrives. Flag values are compared only where the expected enable is high, while the enables themselves are always compared.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW   = 8;
    localparam int NIB  = DW / 2;
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_BIT = 4'd6,
        OP_ASL = 4'd7,
        OP_LSR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic is_zero(input logic [DW-1:0] x);
        return (x == '0);
    endfunction

    function automatic logic nib_ok(input logic [NIB-1:0] x);
        return (x <= NIB'(9));
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          dec,
    input  logic          sub,
    output logic [DW-1:0] res,
    output alu_flags_t    flg
);
    localparam logic [DW:0] HI_LIMIT = (DW+1)'(8'hA0);
    localparam logic [DW:0] HI_FIX   = (DW+1)'(8'h60);

    // binary paths
    logic [DW:0]  bsum, bdiff;
    assign bsum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    assign bdiff = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ~cin};

    // decimal add
    logic [NIB:0] lo_raw, lo_adj;
    logic [DW:0]  hi_raw, hi_adj;
    assign lo_raw = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    assign lo_adj = (lo_raw >= (NIB+1)'(10)) ? lo_raw + (NIB+1)'(6) : lo_raw;
    assign hi_raw = {1'b0, a[DW-1:NIB], {NIB{1'b0}}}
                  + {1'b0, b[DW-1:NIB], {NIB{1'b0}}}
                  + {{(DW-NIB){1'b0}}, lo_adj};
    assign hi_adj = (hi_raw >= HI_LIMIT) ? hi_raw + HI_FIX : hi_raw;

    // decimal subtract
    logic [NIB:0] lo_d, lo_dc;
    logic [DW:0]  hi_d, hi_dc;
    assign lo_d  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, ~cin};
    assign lo_dc = lo_d[NIB] ? lo_d - (NIB+1)'(6) : lo_d;
    assign hi_d  = {1'b0, a[DW-1:NIB], {NIB{1'b0}}}
                 - {1'b0, b[DW-1:NIB], {NIB{1'b0}}}
                 - {{(DW-NIB){1'b0}}, lo_d[NIB], {NIB{1'b0}}};
    assign hi_dc = hi_d[DW] ? hi_d - HI_FIX : hi_d;

    always_comb begin
        if (sub) begin
            res   = dec ? {hi_dc[DW-1:NIB], lo_dc[NIB-1:0]} : bdiff[DW-1:0];
            flg.n = bdiff[DW-1];
            flg.z = is_zero(bdiff[DW-1:0]);
            flg.c = ~bdiff[DW];
            flg.v = (a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ bdiff[DW-1]);
        end else if (dec) begin
            res   = hi_adj[DW-1:0];
            flg.n = hi_raw[DW-1];
            flg.z = is_zero(bsum[DW-1:0]);
            flg.c = hi_adj[DW];
            flg.v = (a[DW-1] ^ hi_raw[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
        end else begin
            res   = bsum[DW-1:0];
            flg.n = bsum[DW-1];
            flg.z = is_zero(bsum[DW-1:0]);
            flg.c = bsum[DW];
            flg.v = (a[DW-1] ^ bsum[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
        end
    end

    logic [DW-1:0] back_sum;
    assign back_sum = res + b + {{(DW-1){1'b0}}, ~cin};

    always_comb begin
        if (!$isunknown({a, b, cin, dec, sub})) begin
            // R4
            sub_inverse_chk: assert (!(sub && !dec) || back_sum == a)
                else $error("binary difference does not invert");
            // R2
            bcd_digit_chk: assert (!(!sub && dec && nib_ok(a[NIB-1:0]) && nib_ok(a[DW-1:NIB])
                                   && nib_ok(b[NIB-1:0]) && nib_ok(b[DW-1:NIB]))
                                   || (nib_ok(res[NIB-1:0]) && nib_ok(res[DW-1:NIB])))
                else $error("decimal sum digit out of range");
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic          right,
    input  logic          rot,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic fill;
    assign fill = rot & cin;

    always_comb begin
        if (right) begin
            res  = {fill, a[DW-1:1]};
            cout = a[0];
        end else begin
            res  = {a[DW-2:0], fill};
            cout = a[DW-1];
        end
    end

    always_comb begin
        if (!$isunknown({a, cin, right, rot})) begin
            // R10
            rot_bits_chk: assert (!rot || $countones({cout, res}) == $countones({cin, a}))
                else $error("rotate lost or gained a bit");
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output alu_flags_t    bit_flg
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_INC:  res = a + DW'(1);
            OP_DEC:  res = a - DW'(1);
            default: res = a;
        endcase
    end

    always_comb begin
        bit_flg.n = b[DW-1];
        bit_flg.v = b[DW-2];
        bit_flg.z = is_zero(a & b);
        bit_flg.c = 1'b0;
    end

    logic [DW-1:0] step_back;
    assign step_back = res - DW'(1);

    always_comb begin
        if (!$isunknown({op, a})) begin
            // R11
            inc_wrap_chk: assert (op != OP_INC || step_back == a)
                else $error("increment does not wrap by one");
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic       carry_i,
    input  logic       decimal_i,
    output logic [7:0] result_o,
    output logic       flag_n_o,
    output logic       flag_z_o,
    output logic       flag_c_o,
    output logic       flag_v_o,
    output logic       upd_n_o,
    output logic       upd_z_o,
    output logic       upd_c_o,
    output logic       upd_v_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic is_cmp, as_sub, as_cin, as_dec;
    assign is_cmp = (op == OP_CMP);
    assign as_sub = (op == OP_SUB) || is_cmp;
    assign as_cin = is_cmp ? 1'b1 : carry_i;
    assign as_dec = decimal_i & ~is_cmp;

    logic [DW-1:0] as_res, sh_res, lg_res;
    alu_flags_t    as_flg, bt_flg;
    logic          sh_c;

    alu8_addsub u_addsub (
        .a(a_i), .b(b_i), .cin(as_cin), .dec(as_dec), .sub(as_sub),
        .res(as_res), .flg(as_flg)
    );

    alu8_shift u_shift (
        .a(a_i), .cin(carry_i),
        .right((op == OP_LSR) || (op == OP_ROR)),
        .rot((op == OP_ROL) || (op == OP_ROR)),
        .res(sh_res), .cout(sh_c)
    );

    alu8_logic u_logic (
        .op(op), .a(a_i), .b(b_i), .res(lg_res), .bit_flg(bt_flg)
    );

    logic [DW-1:0] res;
    alu_flags_t    flg, upd;

    always_comb begin
        res = a_i;
        flg = '0;
        upd = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                res = as_res;
                flg = as_flg;
                upd = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
            end
            OP_CMP: begin
                flg = as_flg;
                upd = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
            end
            OP_BIT: begin
                flg = bt_flg;
                upd = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                res = sh_res;
                flg = '{n: sh_res[DW-1], z: is_zero(sh_res), c: sh_c, v: 1'b0};
                upd = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                res = lg_res;
                flg = '{n: lg_res[DW-1], z: is_zero(lg_res), c: 1'b0, v: 1'b0};
                upd = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
            end
            default: ;
        endcase
    end

    assign result_o = res;
    assign flag_n_o = flg.n;
    assign flag_z_o = flg.z;
    assign flag_c_o = flg.c;
    assign flag_v_o = flg.v;
    assign upd_n_o  = upd.n;
    assign upd_z_o  = upd.z;
    assign upd_c_o  = upd.c;
    assign upd_v_o  = upd.v;

    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, carry_i, decimal_i})) begin
            // R7
            logic_no_cv_chk: assert (!(op_i >= 4'd3 && op_i <= 4'd5) || (!upd_c_o && !upd_v_o))
                else $error("logic op enabled C or V");
            // R12
            reserved_idle_chk: assert (op_i < 4'd13 || (result_o == a_i && !upd_n_o && !upd_z_o
                                       && !upd_c_o && !upd_v_o))
                else $error("reserved op changed state");
            // R6
            cmp_keeps_a_chk: assert (op_i != 4'd2 || result_o == a_i)
                else $error("compare altered the accumulator");
        end
    end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0] op_i;
    logic [7:0] a_i, b_i, result_o;
    logic carry_i, decimal_i;
    logic flag_n_o, flag_z_o, flag_c_o, flag_v_o;
    logic upd_n_o, upd_z_o, upd_c_o, upd_v_o;

    alu8_core u_dut (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .decimal_i(decimal_i),
        .result_o(result_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o),
        .upd_n_o(upd_n_o), .upd_z_o(upd_z_o), .upd_c_o(upd_c_o), .upd_v_o(upd_v_o)
    );

    typedef struct {
        logic [7:0] res;
        logic [3:0] flg;   // {n,z,c,v}
        logic [3:0] en;    // {n,z,c,v}
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    function automatic exp_t model(input int op, input int a, input int b,
                                   input int cin, input int dec, input string tag);
        exp_t e;
        int r, n, z, c, v, s, lo, h;
        r = a; n = 0; z = 0; c = 0; v = 0;
        e.en = 4'b0000;
        case (op)
            0: begin
                s = a + b + cin;
                if (dec != 0) begin
                    lo = (a & 15) + (b & 15) + cin;
                    if (lo > 9) lo = lo + 6;
                    h = (a & 240) + (b & 240) + lo;
                    n = (h >> 7) & 1;
                    v = (((a ^ h) & ~(a ^ b) & 128) != 0) ? 1 : 0;
                    z = ((s & 255) == 0) ? 1 : 0;
                    if (h >= 160) h = h + 96;
                    c = (h >> 8) & 1;
                    r = h & 255;
                end else begin
                    r = s & 255;
                    c = (s >> 8) & 1;
                    v = (((a ^ r) & ~(a ^ b) & 128) != 0) ? 1 : 0;
                    n = (r >> 7) & 1;
                    z = (r == 0) ? 1 : 0;
                end
                e.en = 4'b1111;
            end
            1, 2: begin
                if (op == 2) s = a - b; else s = a - b - (1 - cin);
                r = s & 255;
                c = (s >= 0) ? 1 : 0;
                v = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                n = (r >> 7) & 1;
                z = (r == 0) ? 1 : 0;
                if (op == 1 && dec != 0) begin
                    lo = (a & 15) - (b & 15) - (1 - cin);
                    h = (a & 240) - (b & 240) - ((lo < 0) ? 16 : 0);
                    if (lo < 0) lo = lo - 6;
                    if (h < 0) h = h - 96;
                    r = ((h & 240) | (lo & 15)) & 255;
                end
                if (op == 2) begin r = a; e.en = 4'b1110; end
                else e.en = 4'b1111;
            end
            3, 4, 5, 11, 12: begin
                case (op)
                    3: r = a & b;
                    4: r = a | b;
                    5: r = a ^ b;
                    11: r = (a + 1) & 255;
                    default: r = (a + 255) & 255;
                endcase
                n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
                e.en = 4'b1100;
            end
            6: begin
                n = (b >> 7) & 1; v = (b >> 6) & 1; z = ((a & b) == 0) ? 1 : 0;
                e.en = 4'b1101;
            end
            7, 8, 9, 10: begin
                if (op == 7 || op == 9) begin
                    c = (a >> 7) & 1;
                    r = ((a << 1) & 255) | ((op == 9) ? cin : 0);
                end else begin
                    c = a & 1;
                    r = (a >> 1) | ((op == 10) ? (cin << 7) : 0);
                end
                n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
                e.en = 4'b1110;
            end
            default: ;
        endcase
        e.res = r[7:0];
        e.flg = {n[0], z[0], c[0], v[0]};
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int b,
                         input int cin, input int dec, input string tag);
        @(posedge clk);
        op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0];
        carry_i = cin[0]; decimal_i = dec[0];
        sb_q.push_back(model(op, a, b, cin, dec, tag));
    endtask

    // monitor: outputs are combinational, due in the drive cycle
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            logic [3:0] got_f, got_e;
            e = sb_q.pop_front();
            got_f = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
            got_e = {upd_n_o, upd_z_o, upd_c_o, upd_v_o};
            n_checks++;
            if (result_o !== e.res || got_e !== e.en || (got_f & e.en) !== (e.flg & e.en)) begin
                n_fails++;
                $display("FAIL %s: res=%h en=%b flg=%b expected res=%h en=%b flg=%b",
                         e.tag, result_o, got_e, got_f & e.en, e.res, e.en, e.flg & e.en);
            end
        end
    end

    initial begin
        op_i = 4'd13; a_i = 8'h5A; b_i = 8'h00; carry_i = 1'b0; decimal_i = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R12 idle state with a reserved code
        drive(13, 'h5A, 0, 0, 0, "R12 idle");
        // R1 binary add
        drive(0, 'h50, 'h50, 0, 0, "R1 signed overflow");
        drive(0, 'hFF, 'h01, 0, 0, "R1 carry zero");
        drive(0, 'h12, 'h34, 1, 0, "R1 carry in");
        // R2 / R3 decimal add
        drive(0, 'h58, 'h46, 1, 1, "R2 decimal carry");
        drive(0, 'h99, 'h01, 0, 1, "R3 zero from binary");
        drive(0, 'h15, 'h27, 0, 1, "R2 low nibble fix");
        drive(0, 'h00, 'h00, 0, 1, "R3 zero sum");
        // R4 binary subtract
        drive(1, 'h50, 'hB0, 1, 0, "R4 overflow");
        drive(1, 'h00, 'h01, 1, 0, "R4 borrow");
        drive(1, 'h40, 'h3F, 0, 0, "R4 borrow in");
        // R5 decimal subtract
        drive(1, 'h46, 'h12, 1, 1, "R5 plain");
        drive(1, 'h40, 'h13, 1, 1, "R5 low borrow");
        drive(1, 'h00, 'h01, 1, 1, "R5 wrap");
        // R6 compare ignores carry and decimal
        drive(2, 'h30, 'h30, 0, 1, "R6 equal");
        drive(2, 'h10, 'h20, 1, 0, "R6 less");
        // R7 logic
        drive(3, 'hF0, 'h0F, 1, 0, "R7 and zero");
        drive(4, 'h80, 'h01, 0, 0, "R7 or");
        drive(5, 'hAA, 'hFF, 0, 0, "R7 xor");
        // R8 bit test
        drive(6, 'h01, 'hC0, 1, 0, "R8 bit zero");
        drive(6, 'hFF, 'h41, 0, 0, "R8 bit nonzero");
        // R9 shifts
        drive(7, 'h81, 0, 1, 0, "R9 asl");
        drive(8, 'h01, 0, 1, 0, "R9 lsr");
        // R10 rotates
        drive(9, 'h80, 0, 1, 0, "R10 rol");
        drive(10, 'h01, 0, 1, 0, "R10 ror");
        drive(10, 'h02, 0, 0, 0, "R10 ror no carry");
        // R11 inc/dec wrap
        drive(11, 'hFF, 0, 1, 0, "R11 inc wrap");
        drive(12, 'h00, 0, 0, 0, "R11 dec wrap");
        drive(12, 'h81, 0, 0, 0, "R11 dec");
        // R12 reserved
        drive(15, 'h3C, 'hFF, 1, 1, "R12 reserved");
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule